// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block keeps a small bank of configuration registers for a device whose settings must survive a power cycle. A group of shadowed registers each hold two copies of every bit: a working copy, which drives the device's functional outputs, and a persistent copy, modelled here as a separate register array that stands in for a nonvolatile store. Around the shadowed group sit two single-copy registers: a mode register at the lowest address and an auxiliary register just above the shadowed group.

A single write port (address, data, write strobe) and a combinational read port share one address. A write-protect input that is active low blocks every write. A power-up recall pulse copies the persistent contents into the working copies. A mode bit decides whether a write to a shadowed register reaches both copies or only the working one. When that bit is clear, a write to the mode or auxiliary register also reloads the working copies from the persistent store. Reads of shadowed registers always return the persistent copy, so software can see what will survive a power cycle.

Top module: `shadow_cfg_bank`

## Requirements
- R1: While rst_n is low, every persistent copy and every working copy of shadowed register i (0-based) holds INIT_BASE + i, and the mode and auxiliary registers hold 0.
- R2: A cycle with por_recall_i high copies every persistent copy into its working copy at the next clock edge. This happens even while wp_n_i is low.
- R3: The persist mode bit is bit MODE_BIT (default 0) of the mode register at address 0. When it is 1, an accepted write to a shadowed register (addresses 1 to N_SHADOW) updates both its working and its persistent copy at the next edge.
- R4: When the persist mode bit is 0, an accepted write to a shadowed register updates only its working copy. The persistent copy is unchanged.
- R5: An accepted write to address 0 or to address N_SHADOW+1 recalls all persistent copies into the working copies at the same edge when the resulting mode bit is 0. For a write to address 0, the resulting bit is the newly written data bit, not the old one.
- R6: While wp_n_i is low, every write is ignored, including the recall it would trigger. Reads stay fully available.
- R7: rd_data_o returns, in the same cycle, the following. Address 0 gives the mode register. Addresses 1 to N_SHADOW give the persistent copy of that shadowed register. Address N_SHADOW+1 gives the auxiliary register. Any other address gives 0.
- R8: work_o carries the working copy of shadowed register i in bits [i*DATA_W +: DATA_W]. mode_o and aux_o carry the single-copy registers.
- R9: If a recall and an accepted write to a shadowed register fall in the same cycle, the recall wins. The write is discarded for both copies.
- R10: An accepted write to address 0 or N_SHADOW+1 appears on mode_o or aux_o after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads initial contents |
| por_recall_i | input | 1 | Power-up recall pulse |
| wp_n_i | input | 1 | Write protect, low blocks all writes |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address for write and read |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for addr_i |
| mode_o | output | DATA_W | Mode register contents |
| aux_o | output | DATA_W | Auxiliary register contents |
| work_o | output | N_SHADOW*DATA_W | Working copies of the shadowed registers |

## Verification
Every state change is due exactly one clock edge after the cycle that presents the write, recall pulse or protect level. The read port is combinational and is due in the same cycle as its address. The bench drives inputs just after a falling edge. It compares rd_data_o against its model one time unit later, before any edge. It then advances its behavioural model across the rising edge and compares work_o, mode_o and aux_o at the following falling edge. As a result, every result is sampled in the one cycle in which it is due, and never on an edge.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

   typedef enum logic [1:0] {
      SEL_MODE   = 2'd0,
      SEL_SHADOW = 2'd1,
      SEL_AUX    = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   // Address map: 0 mode, 1..n shadowed, n+1 auxiliary, rest unused
   function automatic reg_sel_e sel_of(input int unsigned addr, input int unsigned n);
      if (addr == 0)
         return SEL_MODE;
      else if (addr <= n)
         return SEL_SHADOW;
      else if (addr == n + 1)
         return SEL_AUX;
      else
         return SEL_NONE;
   endfunction

endpackage

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl
   import shadow_cfg_pkg::*;
#(
   parameter int N_SHADOW = 4,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int MODE_BIT = 0
) (
   input  logic              por_recall_i,
   input  logic              wp_n_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [DATA_W-1:0] mode_q_i,
   output logic              recall_o,
   output logic              mode_we_o,
   output logic              aux_we_o,
   output logic [N_SHADOW-1:0] shadow_we_o,
   output logic              persist_en_o
);

   reg_sel_e sel;
   logic     wr_ok;
   logic     next_mode_bit;
   logic     wr_trig;

   always_comb begin
      sel           = sel_of(32'(addr_i), N_SHADOW);
      wr_ok         = wr_en_i & wp_n_i;
      // a write to the mode register decides with its own new bit
      next_mode_bit = (sel == SEL_MODE) ? wr_data_i[MODE_BIT] : mode_q_i[MODE_BIT];
      wr_trig       = wr_ok & ((sel == SEL_MODE) | (sel == SEL_AUX)) & ~next_mode_bit;
      recall_o      = por_recall_i | wr_trig;
      mode_we_o     = wr_ok & (sel == SEL_MODE);
      aux_we_o      = wr_ok & (sel == SEL_AUX);
      persist_en_o  = mode_q_i[MODE_BIT];
   end

   for (genvar i = 0; i < N_SHADOW; i++) begin : g_we
      // recall outranks a shadowed write in the same cycle
      assign shadow_we_o[i] = wr_ok & (sel == SEL_SHADOW) &
                              (addr_i == ADDR_W'(i + 1)) & ~recall_o;
   end

endmodule

// File: rtl/shadow_cfg_cell.sv
module shadow_cfg_cell #(
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              recall_i,
   input  logic              we_i,
   input  logic              persist_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] work_q_o,
   output logic [DATA_W-1:0] persist_q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q_o    <= INIT;
         persist_q_o <= INIT;
      end else if (recall_i) begin
         work_q_o <= persist_q_o;
      end else if (we_i) begin
         work_q_o <= wdata_i;
         if (persist_en_i)
            persist_q_o <= wdata_i;
      end
   end

   // R2 / R5: a recall loads the working copy from the persistent copy
   a_r2_recall_loads: assert property (@(posedge clk) disable iff (!rst_n)
      recall_i |=> (work_q_o == $past(persist_q_o)));

   // R3: persist-mode write lands in both copies
   a_r3_both_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && persist_en_i && !recall_i) |=> (persist_q_o == work_q_o));

   // R4: volatile-only write leaves the persistent copy alone
   a_r4_volatile_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!persist_en_i) |=> $stable(persist_q_o));

endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
   import shadow_cfg_pkg::*;
#(
   parameter int              N_SHADOW  = 4,
   parameter int              DATA_W    = 8,
   parameter int              ADDR_W    = 3,
   parameter int              MODE_BIT  = 0,
   parameter logic [DATA_W-1:0] INIT_BASE = 8'h30
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       por_recall_i,
   input  logic                       wp_n_i,
   input  logic                       wr_en_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   output logic [DATA_W-1:0]          rd_data_o,
   output logic [DATA_W-1:0]          mode_o,
   output logic [DATA_W-1:0]          aux_o,
   output logic [N_SHADOW*DATA_W-1:0] work_o
);

   localparam int MIN_ADDR_W = $clog2(N_SHADOW + 2);
   localparam int AUX_ADDR   = N_SHADOW + 1;

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end
   if (MODE_BIT >= DATA_W || MODE_BIT < 0) begin : g_bad_mode_bit
      $error("MODE_BIT outside data width");
   end
   if (N_SHADOW < 1) begin : g_bad_count
      $error("N_SHADOW must be at least 1");
   end

   logic                       recall;
   logic                       mode_we;
   logic                       aux_we;
   logic [N_SHADOW-1:0]        shadow_we;
   logic                       persist_en;
   logic [DATA_W-1:0]          mode_q;
   logic [DATA_W-1:0]          aux_q;
   logic [N_SHADOW*DATA_W-1:0] persist_flat;
   logic [N_SHADOW*DATA_W-1:0] work_flat;

   shadow_cfg_ctrl #(
      .N_SHADOW(N_SHADOW),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .MODE_BIT(MODE_BIT)
   ) u_ctrl (
      .por_recall_i(por_recall_i),
      .wp_n_i      (wp_n_i),
      .wr_en_i     (wr_en_i),
      .addr_i      (addr_i),
      .wr_data_i   (wr_data_i),
      .mode_q_i    (mode_q),
      .recall_o    (recall),
      .mode_we_o   (mode_we),
      .aux_we_o    (aux_we),
      .shadow_we_o (shadow_we),
      .persist_en_o(persist_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         aux_q  <= '0;
      end else begin
         if (mode_we) mode_q <= wr_data_i;
         if (aux_we)  aux_q  <= wr_data_i;
      end
   end

   for (genvar i = 0; i < N_SHADOW; i++) begin : g_cell
      shadow_cfg_cell #(
         .DATA_W(DATA_W),
         .INIT  (INIT_BASE + DATA_W'(i))
      ) u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .recall_i    (recall),
         .we_i        (shadow_we[i]),
         .persist_en_i(persist_en),
         .wdata_i     (wr_data_i),
         .work_q_o    (work_flat[i*DATA_W +: DATA_W]),
         .persist_q_o (persist_flat[i*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      rd_data_o = '0;
      unique case (sel_of(32'(addr_i), N_SHADOW))
         SEL_MODE:   rd_data_o = mode_q;
         SEL_SHADOW: begin
            for (int k = 0; k < N_SHADOW; k++)
               if (addr_i == ADDR_W'(k + 1))
                  rd_data_o = persist_flat[k*DATA_W +: DATA_W];
         end
         SEL_AUX:    rd_data_o = aux_q;
         default:    rd_data_o = '0;
      endcase
   end

   assign mode_o = mode_q;
   assign aux_o  = aux_q;
   assign work_o = work_flat;

   // R6: with protect low and no power-up pulse nothing moves
   a_r6_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n_i && !por_recall_i) |=> ($stable(mode_q) && $stable(aux_q) &&
                                      $stable(persist_flat) && $stable(work_flat)));

   // R10: accepted auxiliary write shows up after one edge
   a_r10_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_n_i && wr_en_i && addr_i == ADDR_W'(AUX_ADDR)) |=> (aux_o == $past(wr_data_i)));

   // R10: accepted mode write shows up after one edge
   a_r10_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_n_i && wr_en_i && addr_i == '0) |=> (mode_o == $past(wr_data_i)));

endmodule

// File: tb/shadow_cfg_bank_test.sv
`timescale 1ns/1ps
module shadow_cfg_bank_test;

   localparam int N      = 4;
   localparam int DW     = 8;
   localparam int AW     = 3;
   localparam logic [7:0] IB = 8'h30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          por = 1'b0;
   logic          wpn = 1'b1;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wd = '0;
   logic [DW-1:0] rd_data;
   logic [DW-1:0] mode_out;
   logic [DW-1:0] aux_out;
   logic [N*DW-1:0] work_out;

   int errors = 0;
   int checks = 0;

   // reference state
   logic [7:0] m_mode;
   logic [7:0] m_aux;
   logic [7:0] m_work [N];
   logic [7:0] m_pers [N];

   always #2.5 clk = ~clk;

   shadow_cfg_bank #(.N_SHADOW(N), .DATA_W(DW), .ADDR_W(AW), .MODE_BIT(0), .INIT_BASE(IB)) uut (
      .clk(clk), .rst_n(rst_n), .por_recall_i(por), .wp_n_i(wpn), .wr_en_i(we),
      .addr_i(addr), .wr_data_i(wd), .rd_data_o(rd_data), .mode_o(mode_out),
      .aux_o(aux_out), .work_o(work_out)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] model_rd(input int a);
      if (a == 0) return m_mode;
      if (a >= 1 && a <= N) return m_pers[a-1];
      if (a == N + 1) return m_aux;
      return 8'h00;
   endfunction

   task automatic check_state(input string tag);
      chk(tag, "mode_o", 32'(mode_out), 32'(m_mode));
      chk(tag, "aux_o", 32'(aux_out), 32'(m_aux));
      for (int i = 0; i < N; i++)
         chk(tag, $sformatf("work_o[%0d]", i), 32'(work_out[i*DW +: DW]), 32'(m_work[i]));
   endtask

   // one cycle: drive at the falling edge, check read, cross rising edge, check state
   task automatic step(input string tag, input logic p, input logic w, input logic e,
                       input int a, input logic [7:0] d);
      logic ok, nb, rec;
      por = p; wpn = w; we = e; addr = AW'(a); wd = d;
      #1;
      chk(tag, $sformatf("rd_data@%0d", a), 32'(rd_data), 32'(model_rd(a)));
      ok  = e && w;
      nb  = (a == 0) ? d[0] : m_mode[0];
      rec = p || (ok && (a == 0 || a == N + 1) && !nb);
      if (rec) begin
         for (int i = 0; i < N; i++) m_work[i] = m_pers[i];
      end else if (ok && a >= 1 && a <= N) begin
         m_work[a-1] = d;
         if (m_mode[0]) m_pers[a-1] = d;
      end
      if (ok && a == 0) m_mode = d;
      if (ok && a == N + 1) m_aux = d;
      @(negedge clk);
      check_state(tag);
   endtask

   task automatic peek(input string tag, input int a);
      step(tag, 1'b0, 1'b1, 1'b0, a, 8'h00);
   endtask

   initial begin : watchdog
      #1000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      m_mode = 8'h00;
      m_aux  = 8'h00;
      for (int i = 0; i < N; i++) begin
         m_work[i] = IB + 8'(i);
         m_pers[i] = IB + 8'(i);
      end
      repeat (3) @(negedge clk);
      check_state("R1 reset");
      rst_n = 1'b1;
      for (int a = 0; a < 8; a++) peek("R1 R7 reset read", a);

      // R4: mode bit 0, shadowed write reaches only the working copy
      step("R4 volatile write", 0, 1, 1, 1, 8'h11);
      peek("R4 R7 persistent read", 1);
      // R2: power-up recall restores it
      step("R2 power-up recall", 1, 1, 0, 0, 8'h00);
      // R10: set persist mode
      step("R10 mode write", 0, 1, 1, 0, 8'h01);
      // R3: both copies
      step("R3 persist write", 0, 1, 1, 2, 8'h22);
      peek("R3 R7 read back", 2);
      // R5 via auxiliary with mode clear
      step("R10 mode clear", 0, 1, 1, 0, 8'h00);
      step("R4 volatile write", 0, 1, 1, 4, 8'h44);
      step("R5 aux write recall", 0, 1, 1, N + 1, 8'h55);
      step("R4 volatile write", 0, 1, 1, 3, 8'h66);
      // R5: new mode bit 1 written to addr 0 -> no recall
      step("R5 new bit blocks recall", 0, 1, 1, 0, 8'h81);
      // R5: mode was 1, write 0 -> recall with new bit
      step("R5 new bit triggers recall", 0, 1, 1, 0, 8'h80);
      // R6: protect low
      step("R4 volatile write", 0, 1, 1, 1, 8'h77);
      step("R6 mode write ignored", 0, 0, 1, 0, 8'h01);
      step("R6 aux write ignored", 0, 0, 1, N + 1, 8'h99);
      step("R6 shadow write ignored", 0, 0, 1, 2, 8'hEE);
      step("R6 read allowed", 0, 0, 0, 2, 8'h00);
      // R2: power-up recall works while protected
      step("R2 recall under protect", 1, 0, 0, 1, 8'h00);
      // R9: recall and shadowed write together
      step("R10 mode set", 0, 1, 1, 0, 8'h01);
      step("R9 recall beats write", 1, 1, 1, 3, 8'hAB);
      peek("R9 persistent kept", 3);
      // R7: unused addresses read 0
      peek("R7 unused", 6);
      peek("R7 unused", 7);
      // R8: mixed traffic
      for (int k = 0; k < 400; k++) begin
         automatic int unsigned r = $urandom;
         step("R8 mixed", (r[3:0] == 0), (r[7:4] != 0), r[8], int'(r[11:9]), 8'(r[23:16]));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule